// File: doc/BRIEF.md
# Framebuffer pixel format unpacker

This block takes 32-bit words read from a framebuffer and splits each word into pixels. It sends the pixels out one per beat over a valid/ready handshake. At 1, 2, 4 and 8 bits per pixel the output is a palette index. At 12, 16 and 32 bits per pixel the output is a 24-bit RGB triple with components in the order red, green, blue from the most significant byte down. Fetching words from memory and looking up the palette are done elsewhere. Static controls, held steady while a word is being unpacked, set the following:
- the depth code;
- the byte order and the pixel order;
- the colour-order (BGR) bit;
- a 2-bit board-level select that chooses the 16-bit layout.

The parameter `EXTENDED` selects the variant. The base variant decodes 16-bit pixels through the external select. The extended variant has separate depth codes for the 5551, 565 and 444 layouts. A combinational side output gives the byte length of one display line for a given column count.

Top module: `pix_unpack`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: A word is taken on a clock edge where `in_valid` and `in_ready` are both 1. Its first pixel is valid from the next cycle. `in_ready` stays 0 until the edge that consumes the last pixel of that word. A pixel that is not taken (`out_ready` 0) stays on the outputs unchanged.
- R3: Pixels per word by depth code: 0 gives 32, 1 gives 16, 2 gives 8, 3 gives 4, codes 4, 6 and 7 give 2, and code 5 gives 1. All codes are 1, 2, 4, 8, 16, 32, 16 and 12 bits per pixel in order, and a 12-bit pixel takes a 16-bit slot.
- R4: In index depths (codes 0 to 3), `out_index` is the pixel field zero-extended and `out_rgb` is 0. In every other depth, `out_index` is 0.
- R5: Pixel order:
  - With `big_byte` clear and `big_pix` clear, pixel k is taken from word bits starting at k·bpp.
  - With `big_byte` set, pixels are taken from the most significant end of the word. This applies whatever the value of `big_pix`.
  - With only `big_pix` set, bytes are taken from the low end of the word. Sub-byte pixels inside each byte are taken from its most significant end. Depths of 8 bits and more behave as in the first case.
- R6: Colour fields inside a pixel are named low, mid and high from bit 0 upward. With `bgr` set, red is the low field and blue the high field. With `bgr` clear, red is the high field and blue the low field.
- R7: Field layouts and widening:
  - 32-bit layout: low is bits 7:0, mid is bits 15:8, high is bits 23:16. Bits 31:24 are ignored.
  - 5551 layout: low is bits 4:0, mid is bits 9:5, high is bits 14:10. Bit 15 is ignored.
  - 565 layout: low is bits 4:0, mid is bits 10:5, high is bits 15:11.
  - 444 layout: low is bits 3:0, mid is bits 7:4, high is bits 11:8.
  - Components narrower than 8 bits are shifted left and the low bits are filled with zeros.
- R8: Base variant, depth code 4: with `fmt_sel` 1 the layout is 5551 and follows `bgr`. With `fmt_sel` 3 the layout is 565 and red is the low field whatever `bgr` is. With `fmt_sel` 0 or 2 the layout is 565 and follows `bgr`.
- R9: In the base variant, depth codes 6 and 7 give 2 pixels per word with `out_rgb` 0.
- R10: Extended variant: code 4 is 5551, code 6 is 565 and code 7 is 444, each following `bgr`. `fmt_sel` has no effect.
- R11: `line_bytes` is `cols` divided by 8, 4 or 2 (rounded down) for codes 0, 1 and 2. It is `cols` for code 3, `cols`×2 for codes 4, 6 and 7, and `cols`×4 for code 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Framebuffer word offered |
| in_data | input | 32 | Framebuffer word |
| in_ready | output | 1 | Word will be taken on this edge |
| out_valid | output | 1 | Pixel present |
| out_ready | input | 1 | Pixel consumer ready |
| out_index | output | 8 | Palette index (index depths) |
| out_rgb | output | 24 | Red, green, blue (direct depths) |
| depth | input | 3 | Depth code |
| big_byte | input | 1 | Big-endian byte order, takes priority |
| big_pix | input | 1 | Big-endian pixel order inside bytes |
| bgr | input | 1 | Colour order bit |
| fmt_sel | input | 2 | External 16-bit layout select |
| cols | input | COL_W | Columns per line |
| line_bytes | output | COL_W+2 | Bytes per line |

## Verification
Two events can fall in the same clock edge: the last pixel of a word being consumed and the next word being offered. The bench keeps `in_valid` high with a new word through a stall and then through the final pixel handshake. A correct block takes the new word only on the edge after the old word is fully drained. The bench checks that `in_ready` stays 0 during the stall and that the held pixel does not change. It then checks that the pixel after the handshake is the first pixel of the new word, with no pixel lost or repeated. Base and extended instances receive the same stimulus, so the layout choice by external select and by depth code is judged on the same words.

// File: rtl/pixu_pkg.sv
package pixu_pkg;

   localparam int WORD_W = 32;
   localparam int IDX_W  = 8;
   localparam int RGB_W  = 24;
   localparam int CNT_W  = $clog2(WORD_W);

   typedef enum logic [2:0] {
      DEP_1   = 3'd0,
      DEP_2   = 3'd1,
      DEP_4   = 3'd2,
      DEP_8   = 3'd3,
      DEP_16  = 3'd4,
      DEP_32  = 3'd5,
      DEP_565 = 3'd6,
      DEP_12  = 3'd7
   } depth_e;

   typedef enum logic [1:0] {
      ORD_LE      = 2'd0,
      ORD_BYTE_BE = 2'd1,
      ORD_PIX_BE  = 2'd2
   } order_e;

   typedef enum logic [2:0] {
      FMT_NONE = 3'd0,
      FMT_5551 = 3'd1,
      FMT_565  = 3'd2,
      FMT_444  = 3'd3,
      FMT_888  = 3'd4
   } fmt_e;

   // log2 of the slot width a depth code occupies in the word
   function automatic logic [2:0] slot_lg(input logic [2:0] d);
      case (depth_e'(d))
         DEP_1:   slot_lg = 3'd0;
         DEP_2:   slot_lg = 3'd1;
         DEP_4:   slot_lg = 3'd2;
         DEP_8:   slot_lg = 3'd3;
         DEP_32:  slot_lg = 3'd5;
         default: slot_lg = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/pixu_field_pick.sv
module pixu_field_pick
   import pixu_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   input  logic [CNT_W-1:0]  slot,
   input  logic [2:0]        lg,
   input  order_e            order,
   output logic [RGB_W-1:0]  field
);

   localparam int OFF_W = CNT_W + 1;

   logic [OFF_W-1:0] bpp;
   logic [OFF_W-1:0] pos;
   logic [OFF_W-1:0] off;
   logic [WORD_W-1:0] shifted;

   always_comb begin
      bpp = OFF_W'(1) << lg;
      pos = {1'b0, slot} << lg;
      case (order)
         ORD_BYTE_BE: off = OFF_W'(WORD_W) - (({1'b0, slot} + OFF_W'(1)) << lg);
         ORD_PIX_BE: begin
            if (lg < 3'd3)
               off = {pos[OFF_W-1:3], 3'b000} + OFF_W'(8) - bpp - {{(OFF_W-3){1'b0}}, pos[2:0]};
            else
               off = pos;
         end
         default: off = pos;
      endcase
      shifted = word >> off;
      field   = shifted[RGB_W-1:0];
   end

endmodule

// File: rtl/pixu_color.sv
module pixu_color
   import pixu_pkg::*;
#(
   parameter int EXTENDED = 0
) (
   input  logic [RGB_W-1:0] field,
   input  logic [2:0]       depth,
   input  logic             bgr,
   input  logic [1:0]       fmt_sel,
   output logic [RGB_W-1:0] rgb
);

   fmt_e fmt;
   logic red_low;
   logic [7:0] lo, mid, hi;

   generate
      if (EXTENDED != 0) begin : g_ext
         always_comb begin
            red_low = bgr;
            case (depth_e'(depth))
               DEP_16:  fmt = FMT_5551;
               DEP_565: fmt = FMT_565;
               DEP_12:  fmt = FMT_444;
               DEP_32:  fmt = FMT_888;
               default: fmt = FMT_NONE;
            endcase
         end
      end else begin : g_base
         always_comb begin
            red_low = bgr;
            case (depth_e'(depth))
               DEP_16: begin
                  case (fmt_sel)
                     2'd1:    fmt = FMT_5551;
                     2'd3: begin
                        fmt     = FMT_565;
                        red_low = 1'b1;
                     end
                     default: fmt = FMT_565;
                  endcase
               end
               DEP_32:  fmt = FMT_888;
               default: fmt = FMT_NONE;
            endcase
         end
      end
   endgenerate

   always_comb begin
      lo  = '0;
      mid = '0;
      hi  = '0;
      case (fmt)
         FMT_5551: begin
            lo  = {field[4:0], 3'b000};
            mid = {field[9:5], 3'b000};
            hi  = {field[14:10], 3'b000};
         end
         FMT_565: begin
            lo  = {field[4:0], 3'b000};
            mid = {field[10:5], 2'b00};
            hi  = {field[15:11], 3'b000};
         end
         FMT_444: begin
            lo  = {field[3:0], 4'b0000};
            mid = {field[7:4], 4'b0000};
            hi  = {field[11:8], 4'b0000};
         end
         FMT_888: begin
            lo  = field[7:0];
            mid = field[15:8];
            hi  = field[23:16];
         end
         default: ;
      endcase
      rgb = red_low ? {lo, mid, hi} : {hi, mid, lo};
   end

endmodule

// File: rtl/pixu_pitch.sv
module pixu_pitch
   import pixu_pkg::*;
#(
   parameter int COL_W = 12
) (
   input  logic [COL_W-1:0] cols,
   input  logic [2:0]       depth,
   output logic [COL_W+1:0] line_bytes
);

   localparam int LB_W = COL_W + 2;

   logic [LB_W-1:0] c;

   always_comb begin
      c = LB_W'(cols);
      case (depth_e'(depth))
         DEP_1:   line_bytes = c >> 3;
         DEP_2:   line_bytes = c >> 2;
         DEP_4:   line_bytes = c >> 1;
         DEP_8:   line_bytes = c;
         DEP_32:  line_bytes = c << 2;
         default: line_bytes = c << 1;
      endcase
   end

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
   import pixu_pkg::*;
#(
   parameter int COL_W    = 12,
   parameter int EXTENDED = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [WORD_W-1:0]   in_data,
   output logic                in_ready,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [IDX_W-1:0]    out_index,
   output logic [RGB_W-1:0]    out_rgb,
   input  logic [2:0]          depth,
   input  logic                big_byte,
   input  logic                big_pix,
   input  logic                bgr,
   input  logic [1:0]          fmt_sel,
   input  logic [COL_W-1:0]    cols,
   output logic [COL_W+1:0]    line_bytes
);

   generate
      if (COL_W < 4 || COL_W > 24) begin : g_bad_colw
         $error("pix_unpack: COL_W must lie in 4..24");
      end
      if (EXTENDED != 0 && EXTENDED != 1) begin : g_bad_ext
         $error("pix_unpack: EXTENDED must be 0 or 1");
      end
   endgenerate

   logic              full;
   logic [CNT_W-1:0]  slot;
   logic [WORD_W-1:0] word;
   logic [2:0]        lg;
   logic [CNT_W-1:0]  last_slot;
   logic              last;
   order_e            order;
   logic [RGB_W-1:0]  field;
   logic [RGB_W-1:0]  rgb_dec;
   logic [IDX_W-1:0]  idx_mask;

   assign lg        = slot_lg(depth);
   assign last_slot = CNT_W'((CNT_W+1)'(WORD_W) >> lg) - CNT_W'(1);
   assign last      = (slot == last_slot);
   assign order     = big_byte ? ORD_BYTE_BE : (big_pix ? ORD_PIX_BE : ORD_LE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         slot <= '0;
         word <= '0;
      end else if (!full) begin
         if (in_valid) begin
            word <= in_data;
            full <= 1'b1;
            slot <= '0;
         end
      end else if (out_ready) begin
         if (last)
            full <= 1'b0;
         else
            slot <= slot + CNT_W'(1);
      end
   end

   pixu_field_pick u_pick (
      .word  (word),
      .slot  (slot),
      .lg    (lg),
      .order (order),
      .field (field)
   );

   pixu_color #(.EXTENDED(EXTENDED)) u_color (
      .field   (field),
      .depth   (depth),
      .bgr     (bgr),
      .fmt_sel (fmt_sel),
      .rgb     (rgb_dec)
   );

   pixu_pitch #(.COL_W(COL_W)) u_pitch (
      .cols       (cols),
      .depth      (depth),
      .line_bytes (line_bytes)
   );

   always_comb begin
      case (lg)
         3'd0:    idx_mask = 8'h01;
         3'd1:    idx_mask = 8'h03;
         3'd2:    idx_mask = 8'h0F;
         3'd3:    idx_mask = 8'hFF;
         default: idx_mask = 8'h00;
      endcase
   end

   assign in_ready  = ~full;
   assign out_valid = full;
   assign out_index = field[IDX_W-1:0] & idx_mask;
   assign out_rgb   = (lg >= 3'd4) ? rgb_dec : '0;

endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk
   import pixu_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [IDX_W-1:0]  out_index,
   input logic [RGB_W-1:0]  out_rgb,
   input logic [2:0]        depth,
   input logic              big_byte,
   input logic              big_pix,
   input logic              bgr,
   input logic [1:0]        fmt_sel
);

   logic [CNT_W:0] beats;
   logic [2:0]     word_depth;
   logic           seen;
   logic [CNT_W:0] want;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beats      <= '0;
         word_depth <= '0;
         seen       <= 1'b0;
      end else if (in_valid && in_ready) begin
         beats      <= '0;
         word_depth <= depth;
         seen       <= 1'b1;
      end else if (out_valid && out_ready) begin
         beats <= beats + 1'b1;
      end
   end

   always_comb begin
      case (word_depth)
         3'd0:    want = (CNT_W+1)'(32);
         3'd1:    want = (CNT_W+1)'(16);
         3'd2:    want = (CNT_W+1)'(8);
         3'd3:    want = (CNT_W+1)'(4);
         3'd5:    want = (CNT_W+1)'(1);
         default: want = (CNT_W+1)'(2);
      endcase
   end

   // R1
   reset_idle_chk: assert property (@(posedge clk) !rst_n |-> !out_valid && in_ready);

   // R2
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && !in_ready));

   // R2
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> out_valid);

   // R2
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(out_valid && !out_ready) && $stable({depth, big_byte, big_pix, bgr, fmt_sel}))
      |-> ($stable(out_index) && $stable(out_rgb)));

   // R3
   beat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && seen) |-> (beats == want));

   // R4
   idx_rgb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && depth <= 3'd3) |-> (out_rgb == '0));

endmodule

bind pix_unpack pix_unpack_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_index (out_index),
   .out_rgb   (out_rgb),
   .depth     (depth),
   .big_byte  (big_byte),
   .big_pix   (big_pix),
   .bgr       (bgr),
   .fmt_sel   (fmt_sel)
);

// File: tb/sim_pix_unpack.sv
`timescale 1ns/1ps
module sim_pix_unpack;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        out_ready = 1'b0;
   logic [2:0]  depth = 3'd3;
   logic        big_byte = 1'b0;
   logic        big_pix = 1'b0;
   logic        bgr = 1'b0;
   logic [1:0]  fmt_sel = 2'd0;
   logic [11:0] cols = 12'd0;

   logic        rdy0, rdy1, ov0, ov1;
   logic [7:0]  idx0, idx1;
   logic [23:0] rgb0, rgb1;
   logic [13:0] lb0, lb1;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pix_unpack #(.COL_W(12), .EXTENDED(0)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(rdy0),
      .out_valid(ov0), .out_ready(out_ready), .out_index(idx0), .out_rgb(rgb0),
      .depth(depth), .big_byte(big_byte), .big_pix(big_pix), .bgr(bgr), .fmt_sel(fmt_sel),
      .cols(cols), .line_bytes(lb0));

   pix_unpack #(.COL_W(12), .EXTENDED(1)) u1 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(rdy1),
      .out_valid(ov1), .out_ready(out_ready), .out_index(idx1), .out_rgb(rgb1),
      .depth(depth), .big_byte(big_byte), .big_pix(big_pix), .bgr(bgr), .fmt_sel(fmt_sel),
      .cols(cols), .line_bytes(lb1));

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic load(input logic [31:0] w);
      check(rdy0 && rdy1 && !ov0 && !ov1, "R2 ready for new word", {30'd0, rdy0, rdy1}, 32'h3);
      in_valid = 1'b1;
      in_data  = w;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic pix(input logic [7:0] ei, input logic [23:0] eb, input logic [23:0] ee, input string tag);
      checks++;
      if (!(ov0 && ov1 && !rdy0 && !rdy1 && idx0 == ei && idx1 == ei && rgb0 == eb && rgb1 == ee)) begin
         fails++;
         $display("FAIL %s: actual valid %b%b ready %b%b idx %h/%h rgb %h/%h, expected valid 11 ready 00 idx %h rgb %h/%h",
                  tag, ov0, ov1, rdy0, rdy1, idx0, idx1, rgb0, rgb1, ei, eb, ee);
      end
      out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic set_cfg(input logic [2:0] d, input logic bb, input logic bp, input logic b, input logic [1:0] f);
      depth = d; big_byte = bb; big_pix = bp; bgr = b; fmt_sel = f;
   endtask

   task automatic t_reset();
      check(!ov0 && !ov1 && rdy0 && rdy1, "R1 idle after reset", {28'd0, ov0, ov1, rdy0, rdy1}, 32'h3);
   endtask

   task automatic t_8bpp();
      set_cfg(3'd3, 0, 0, 0, 2'd0);
      load(32'h44332211);
      pix(8'h11, 0, 0, "R4 R5 8bpp LE p0"); pix(8'h22, 0, 0, "R5 8bpp LE p1");
      pix(8'h33, 0, 0, "R5 8bpp LE p2");   pix(8'h44, 0, 0, "R3 R5 8bpp LE p3");
      set_cfg(3'd3, 1, 0, 0, 2'd0);
      load(32'h44332211);
      pix(8'h44, 0, 0, "R5 8bpp byte BE p0"); pix(8'h33, 0, 0, "R5 8bpp byte BE p1");
      pix(8'h22, 0, 0, "R5 8bpp byte BE p2"); pix(8'h11, 0, 0, "R5 8bpp byte BE p3");
      set_cfg(3'd3, 0, 1, 0, 2'd0);
      load(32'h44332211);
      pix(8'h11, 0, 0, "R5 8bpp pix BE p0"); pix(8'h22, 0, 0, "R5 8bpp pix BE p1");
      pix(8'h33, 0, 0, "R5 8bpp pix BE p2"); pix(8'h44, 0, 0, "R5 8bpp pix BE p3");
   endtask

   task automatic t_4bpp();
      set_cfg(3'd2, 0, 0, 0, 2'd0);
      load(32'h87654321);
      for (int i = 0; i < 8; i++) pix(8'(i + 1), 0, 0, "R3 R5 4bpp LE");
      set_cfg(3'd2, 0, 1, 0, 2'd0);
      load(32'h87654321);
      for (int i = 0; i < 8; i++) pix(8'((i ^ 1) + 1), 0, 0, "R5 4bpp pix BE");
      set_cfg(3'd2, 1, 0, 0, 2'd0);
      load(32'h87654321);
      for (int i = 0; i < 8; i++) pix(8'(8 - i), 0, 0, "R5 4bpp byte BE");
      set_cfg(3'd2, 1, 1, 0, 2'd0);
      load(32'h87654321);
      for (int i = 0; i < 8; i++) pix(8'(8 - i), 0, 0, "R5 4bpp byte BE over pix BE");
   endtask

   task automatic t_low_depths();
      set_cfg(3'd1, 0, 0, 0, 2'd0);
      load(32'h000000E4);
      for (int i = 0; i < 16; i++) pix(i < 4 ? 8'(i) : 8'd0, 0, 0, "R3 R5 2bpp LE");
      set_cfg(3'd1, 0, 1, 0, 2'd0);
      load(32'h000000E4);
      for (int i = 0; i < 16; i++) pix(i < 4 ? 8'(3 - i) : 8'd0, 0, 0, "R5 2bpp pix BE");
      set_cfg(3'd0, 0, 0, 0, 2'd0);
      load(32'h00000005);
      for (int i = 0; i < 32; i++) pix((i == 0 || i == 2) ? 8'd1 : 8'd0, 0, 0, "R3 R5 1bpp LE");
      set_cfg(3'd0, 1, 0, 0, 2'd0);
      load(32'hA0000000);
      for (int i = 0; i < 32; i++) pix((i == 0 || i == 2) ? 8'd1 : 8'd0, 0, 0, "R5 1bpp byte BE");
   endtask

   task automatic t_32bpp();
      set_cfg(3'd5, 0, 0, 1, 2'd0);
      load(32'hFFABCDEF);
      pix(8'd0, 24'hEFCDAB, 24'hEFCDAB, "R3 R6 R7 32bpp bgr set");
      set_cfg(3'd5, 0, 0, 0, 2'd0);
      load(32'hFFABCDEF);
      pix(8'd0, 24'hABCDEF, 24'hABCDEF, "R4 R6 32bpp bgr clear");
   endtask

   task automatic t_16bpp();
      set_cfg(3'd4, 0, 0, 1, 2'd1);
      load(32'h0000FCA3);
      pix(0, 24'h1828F8, 24'h1828F8, "R7 R8 sel1 bgr1"); pix(0, 0, 0, "R3 16bpp p1");
      set_cfg(3'd4, 0, 0, 0, 2'd1);
      load(32'h0000FCA3);
      pix(0, 24'hF82818, 24'hF82818, "R8 sel1 bgr0"); pix(0, 0, 0, "R8 p1");
      set_cfg(3'd4, 0, 0, 0, 2'd3);
      load(32'h0000FCA3);
      pix(0, 24'h1894F8, 24'hF82818, "R8 R10 sel3 forces low red"); pix(0, 0, 0, "R8 p1");
      set_cfg(3'd4, 0, 0, 0, 2'd0);
      load(32'h0000FCA3);
      pix(0, 24'hF89418, 24'hF82818, "R8 R10 sel0 565 bgr0"); pix(0, 0, 0, "R8 p1");
      set_cfg(3'd4, 0, 0, 1, 2'd2);
      load(32'h0000FCA3);
      pix(0, 24'h1894F8, 24'h1828F8, "R8 R10 sel2 565 bgr1"); pix(0, 0, 0, "R8 p1");
      set_cfg(3'd4, 1, 0, 1, 2'd1);
      load(32'h0000FCA3);
      pix(0, 0, 0, "R5 16bpp byte BE p0"); pix(0, 24'h1828F8, 24'h1828F8, "R5 16bpp byte BE p1");
   endtask

   task automatic t_ext_codes();
      set_cfg(3'd6, 0, 0, 1, 2'd1);
      load(32'h0000FCA3);
      pix(0, 0, 24'h1894F8, "R9 R10 code6 565"); pix(0, 0, 0, "R9 code6 p1");
      set_cfg(3'd7, 0, 0, 1, 2'd3);
      load(32'h0000FABC);
      pix(0, 0, 24'hC0B0A0, "R7 R9 R10 code7 444 bgr1"); pix(0, 0, 0, "R9 code7 p1");
      set_cfg(3'd7, 0, 0, 0, 2'd0);
      load(32'h0000FABC);
      pix(0, 0, 24'hA0B0C0, "R10 code7 444 bgr0"); pix(0, 0, 0, "R9 code7 p1");
   endtask

   task automatic t_stall_overlap();
      set_cfg(3'd5, 0, 0, 0, 2'd0);
      load(32'h00123456);
      in_valid = 1'b1;
      in_data  = 32'h00654321;
      for (int i = 0; i < 5; i++) begin
         check(ov0 && !rdy0 && rgb0 == 24'h123456 && rgb1 == 24'h123456, "R2 stall hold",
               {8'd0, rgb0}, 32'h00123456);
         @(posedge clk);
         @(negedge clk);
      end
      out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      out_ready = 1'b0;
      check(!ov0 && !ov1 && rdy0 && rdy1, "R2 drained before next word", {30'd0, ov0, rdy0}, 32'h1);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      pix(0, 24'h654321, 24'h654321, "R2 next word after overlap");
   endtask

   task automatic t_pitch();
      logic [13:0] exp640 [8];
      exp640 = '{14'd80, 14'd160, 14'd320, 14'd640, 14'd1280, 14'd2560, 14'd1280, 14'd1280};
      cols = 12'd640;
      for (int d = 0; d < 8; d++) begin
         depth = 3'(d);
         #1;
         check(lb0 == exp640[d] && lb1 == exp640[d], "R11 line bytes 640 cols", {18'd0, lb0}, {18'd0, exp640[d]});
      end
      cols = 12'd13;
      depth = 3'd0; #1; check(lb0 == 14'd1 && lb1 == 14'd1, "R11 13 cols 1bpp", {18'd0, lb0}, 32'd1);
      depth = 3'd1; #1; check(lb0 == 14'd3 && lb1 == 14'd3, "R11 13 cols 2bpp", {18'd0, lb0}, 32'd3);
      depth = 3'd2; #1; check(lb0 == 14'd6 && lb1 == 14'd6, "R11 13 cols 4bpp", {18'd0, lb0}, 32'd6);
      cols = 12'd4095;
      depth = 3'd5; #1; check(lb0 == 14'd16380 && lb1 == 14'd16380, "R11 max cols 32bpp", {18'd0, lb0}, 32'd16380);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_8bpp();
      t_4bpp();
      t_low_depths();
      t_32bpp();
      t_16bpp();
      t_ext_codes();
      t_stall_overlap();
      t_pitch();
      report();
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

endmodule